// File: doc/BRIEF.md
# Low-Power March Address and Precharge Sequencer

This block drives the address side of a memory self-test for a RAM arranged as rows and columns. A start pulse makes it visit every address exactly once, one address per clock cycle. The row is held while the column index runs across the whole row. In the ascending walk the sequence starts at row 0, column 0. The descending walk is the exact reverse of the ascending one. A one-hot column select follows the current column.

The block also drives one precharge enable per column. In normal mode every enable stays high, because a functional access could land on any column. When the low-power command is sampled high at start, the fixed order lets the block precharge only the column being accessed and the column that will be visited next. This cuts precharge current without changing the address order or the set of cells visited. After the final address the block raises done for one cycle and returns to idle, where all enables are high again.

Top module: `lp_precharge_seq`

## Requirements
- R1: After reset the block is idle. busy and done are 0, col_sel is all zeros, row_addr and col_addr are 0, and every bit of pre_en is 1.
- R2: In idle, a start pulse makes busy 1 from the next cycle on. The first address is row 0, column 0 when dir_down is 0, and row ROWS-1, column COLS-1 when dir_down is 1.
- R3: Ascending walk: the block shows one address per cycle. The column goes up by 1, and after column COLS-1 it goes back to 0 while the row goes up by 1.
- R4: Descending walk: the address sequence is the exact reverse of the ascending walk. The column goes down by 1, and after column 0 it goes to COLS-1 while the row goes down by 1.
- R5: While busy, col_sel is one-hot with bit col_addr set. When not busy, col_sel is all zeros.
- R6: In a walk started with lp_mode 0, every bit of pre_en is 1 in every cycle.
- R7: In a walk started with lp_mode 1, exactly two pre_en bits are 1 on every address except the final one: bit col_addr and the bit of the column visited next.
- R8: In low-power mode, at the last column of a row, the successor enable is the first column of the next row in walk order. That is column 0 when ascending and column COLS-1 when descending.
- R9: In low-power mode, on the final address of the walk, only pre_en bit col_addr is 1.
- R10: In the cycle after the final address, done is 1 for exactly one cycle, with busy 0 and all pre_en bits 1. The cycle after that is idle with done 0.
- R11: While busy, start is ignored. lp_mode and dir_down are sampled only at start, so changing them during a walk does not alter the address order or the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a walk; only acted on when idle |
| lp_mode | input | 1 | Low-power precharge command, sampled at start |
| dir_down | input | 1 | 1 = descending walk, sampled at start |
| row_addr | output | $clog2(ROWS) | Current row (word line) |
| col_addr | output | $clog2(COLS) | Current column |
| col_sel | output | COLS | One-hot column select while busy |
| pre_en | output | COLS | Per-column precharge enable |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse after the final address |

## Verification
The hardest case to reach from the ports is a walk that stays correct while its inputs are disturbed partway through. To get there, the bench raises start, flips lp_mode and flips dir_down in the same cycle in the middle of a low-power walk. It then keeps checking every later address and enable against the settings captured at start. The row-boundary successor and the final-address single enable are reached by full walks in both directions. In these walks the bench computes the expected successor from the linear visit index, not from column arithmetic.

// File: rtl/lp_pc_pkg.sv
// Shared types for the low-power precharge sequencer.
package lp_pc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/lp_addr_walker.sv
// Row/column address counter for a march walk.
// Assumes ROWS >= 2 and COLS >= 2. The load input places the counter on the
// first address for the chosen direction. The step input moves it to the next
// address. last_addr flags the final address of the walk.
module lp_addr_walker #(
    parameter int ROWS = 4,
    parameter int COLS = 8,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          down,
    output logic [RW-1:0] row,
    output logic [CW-1:0] col,
    output logic          last_addr
);
    localparam logic [RW-1:0] ROW_MAX = RW'(ROWS - 1);
    localparam logic [CW-1:0] COL_MAX = CW'(COLS - 1);

    // Advance or load the address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
            col <= '0;
        end else if (load) begin
            row <= down ? ROW_MAX : '0;
            col <= down ? COL_MAX : '0;
        end else if (step) begin
            if (!down) begin
                if (col == COL_MAX) begin
                    col <= '0;
                    row <= row + 1'b1;
                end else begin
                    col <= col + 1'b1;
                end
            end else begin
                if (col == '0) begin
                    col <= COL_MAX;
                    row <= row - 1'b1;
                end else begin
                    col <= col - 1'b1;
                end
            end
        end
    end

    // Flag the final address for the current direction.
    always_comb begin
        last_addr = down ? (row == '0 && col == '0)
                         : (row == ROW_MAX && col == COL_MAX);
    end

    // R3 / R4: a step moves the linear index by exactly one in the walk direction.
    logic [RW+CW:0] lin_idx;
    assign lin_idx = (RW+CW+1)'(row) * (RW+CW+1)'(COLS) + (RW+CW+1)'(col);

    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !down && !last_addr) |=> (lin_idx == $past(lin_idx) + 1'b1));
    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && down && !last_addr) |=> (lin_idx == $past(lin_idx) - 1'b1));
endmodule

// File: rtl/lp_precharge_gen.sv
// Column select and precharge enable generator.
// Assumes COLS >= 2. While not active, every enable is high and the select is
// zero. While active in low-power mode, only the current column and the column
// visited next are enabled. On the final address only the current column is
// enabled.
module lp_precharge_gen #(
    parameter int COLS = 8,
    localparam int CW = $clog2(COLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            lp,
    input  logic            down,
    input  logic            last_addr,
    input  logic [CW-1:0]   col,
    output logic [COLS-1:0] col_sel,
    output logic [COLS-1:0] pre_en
);
    localparam logic [CW-1:0] COL_MAX = CW'(COLS - 1);

    logic [CW-1:0] succ;

    // Column visited after the current one, wrapping into the next row.
    always_comb begin
        if (down) succ = (col == '0) ? COL_MAX : col - 1'b1;
        else      succ = (col == COL_MAX) ? '0 : col + 1'b1;
    end

    for (genvar i = 0; i < COLS; i++) begin : g_col
        // Decode the select and the enable for column i.
        always_comb begin
            col_sel[i] = active && (col == CW'(i));
            pre_en[i]  = !active || !lp || (col == CW'(i)) ||
                         (!last_addr && (succ == CW'(i)));
        end
    end

    // R5
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> $onehot(col_sel));
    // R7
    lp_two_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && lp && !last_addr) |-> ($countones(pre_en) == 2));
    // R9
    lp_last_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && lp && last_addr) |-> (pre_en == col_sel));
endmodule

// File: rtl/lp_precharge_seq.sv
// Top of the low-power march sequencer. A small state machine starts a walk
// on start (when idle only), captures the mode and direction, steps the address
// walker once per cycle and pulses done after the final address.
module lp_precharge_seq #(
    parameter int ROWS = 4,
    parameter int COLS = 8,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            lp_mode,
    input  logic            dir_down,
    output logic [RW-1:0]   row_addr,
    output logic [CW-1:0]   col_addr,
    output logic [COLS-1:0] col_sel,
    output logic [COLS-1:0] pre_en,
    output logic            busy,
    output logic            done
);
    import lp_pc_pkg::*;

    seq_state_t state;
    logic       lp_q, down_q;
    logic       load, step, last_addr;

    assign load = (state == ST_IDLE) && start;
    assign step = (state == ST_WALK) && !last_addr;

    // Sequence state and capture of the mode and direction at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            lp_q   <= 1'b0;
            down_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state  <= ST_WALK;
                    lp_q   <= lp_mode;
                    down_q <= dir_down;
                end
                ST_WALK: if (last_addr) state <= ST_FIN;
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Status outputs decoded from the state.
    always_comb begin
        busy = (state == ST_WALK);
        done = (state == ST_FIN);
    end

    lp_addr_walker #(.ROWS(ROWS), .COLS(COLS)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .down      (load ? dir_down : down_q),
        .row       (row_addr),
        .col       (col_addr),
        .last_addr (last_addr)
    );

    lp_precharge_gen #(.COLS(COLS)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (busy),
        .lp        (lp_q),
        .down      (down_q),
        .last_addr (last_addr),
        .col       (col_addr),
        .col_sel   (col_sel),
        .pre_en    (pre_en)
    );

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    idle_full_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&pre_en));
    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(lp_q));
endmodule

// File: tb/lp_precharge_seq_test.sv
module lp_precharge_seq_test;
    localparam int ROWS = 4;
    localparam int COLS = 8;
    localparam int RW = $clog2(ROWS);
    localparam int CW = $clog2(COLS);
    localparam int TOTAL = ROWS * COLS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic lp_mode = 1'b0;
    logic dir_down = 1'b0;
    logic [RW-1:0]   row_addr;
    logic [CW-1:0]   col_addr;
    logic [COLS-1:0] col_sel;
    logic [COLS-1:0] pre_en;
    logic busy, done;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    lp_precharge_seq #(.ROWS(ROWS), .COLS(COLS)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .lp_mode(lp_mode),
        .dir_down(dir_down), .row_addr(row_addr), .col_addr(col_addr),
        .col_sel(col_sel), .pre_en(pre_en), .busy(busy), .done(done)
    );

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R1 status", {busy, done}, 0);
        chk(col_sel == '0, "R1 col_sel", col_sel, 0);
        chk(row_addr == '0 && col_addr == '0, "R1 addr", {row_addr, col_addr}, 0);
        chk(pre_en == '1, "R1 pre_en", pre_en, {COLS{1'b1}});
    endtask

    // Full walk; if disturb is set, start/lp_mode/dir_down are toggled mid-walk (R11).
    task automatic run_walk(input logic lp, input logic down, input logic disturb);
        logic [COLS-1:0] exp_en;
        int idx, nidx, ecol, erow, ncol;
        lp_mode = lp;
        dir_down = down;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < TOTAL; k++) begin
            idx  = down ? TOTAL - 1 - k : k;
            nidx = down ? idx - 1 : idx + 1;
            erow = idx / COLS;
            ecol = idx % COLS;
            if (!lp) exp_en = '1;
            else begin
                exp_en = '0;
                exp_en[ecol] = 1'b1;
                if (k != TOTAL - 1) begin
                    ncol = ((nidx % COLS) + COLS) % COLS;
                    exp_en[ncol] = 1'b1;
                end
            end
            chk(busy == 1 && done == 0, down ? "R2/R4 busy" : "R2/R3 busy", {busy, done}, 2);
            chk(row_addr == RW'(erow) && col_addr == CW'(ecol),
                down ? "R4 address" : "R3 address", {row_addr, col_addr}, {erow[RW-1:0], ecol[CW-1:0]});
            chk(col_sel == (COLS'(1) << ecol), "R5 col_sel", col_sel, COLS'(1) << ecol);
            if (!lp)
                chk(pre_en == exp_en, "R6 pre_en", pre_en, exp_en);
            else if (k == TOTAL - 1)
                chk(pre_en == exp_en, "R9 pre_en", pre_en, exp_en);
            else if (ecol == (down ? 0 : COLS - 1))
                chk(pre_en == exp_en, "R8 pre_en", pre_en, exp_en);
            else
                chk(pre_en == exp_en, "R7 pre_en", pre_en, exp_en);
            if (disturb && k == 9) begin
                start = 1'b1;
                lp_mode = ~lp;
                dir_down = ~down;
            end else if (disturb && k == 10) begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        lp_mode = 1'b0;
        dir_down = 1'b0;
        chk(done == 1 && busy == 0, "R10 done", {done, busy}, 2);
        chk(pre_en == '1 && col_sel == '0, "R10 done enables", pre_en, {COLS{1'b1}});
        @(negedge clk);
        chk(done == 0 && busy == 0, "R10 idle", {done, busy}, 0);
        chk(pre_en == '1, "R10 idle enables", pre_en, {COLS{1'b1}});
    endtask

    // R5: col_sel remains zero in idle even with mode inputs changing.
    task automatic test_idle_quiet();
        lp_mode = 1'b1;
        dir_down = 1'b1;
        repeat (3) @(negedge clk);
        chk(col_sel == '0 && busy == 0, "R5 idle col_sel", col_sel, 0);
        chk(pre_en == '1, "R1 idle pre_en", pre_en, {COLS{1'b1}});
        lp_mode = 1'b0;
        dir_down = 1'b0;
    endtask

    initial begin
        fork
            begin
                test_reset();
                test_idle_quiet();
                run_walk(1'b0, 1'b0, 1'b0);
                run_walk(1'b1, 1'b0, 1'b0);
                run_walk(1'b1, 1'b1, 1'b0);
                run_walk(1'b0, 1'b1, 1'b0);
                run_walk(1'b1, 1'b0, 1'b1);
                run_walk(1'b0, 1'b1, 1'b1);
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=1 expected=0");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule